// File: doc/BRIEF.md
# Coin Credit Tally

This block holds the running credit of a small coin-operated dispenser that accepts two coin denominations. Each single-cycle pulse on the small-coin input adds five cents, and each single-cycle pulse on the large-coin input adds ten cents. The credit is kept in a narrow unsigned register and is driven onto an output bus. A status line shows when the credit has reached its ceiling.

Credit can never rise above a fixed ceiling of thirty cents. Any coin that would carry the credit past that ceiling is refused. A refused coin leaves the credit as it was and raises a one-cycle refusal pulse. If both coin inputs are high in the same cycle, the large coin wins and the small coin is dropped.

The surrounding machine samples `credit` and `at_cap` to decide what can be dispensed. It clears the tally through the asynchronous reset.

Top module: `coin_tally`

## Requirements
- R1: While `rst` is high, and asynchronously when it rises, `credit` is 0, and `refused` and `at_cap` are 0.
- R2: A cycle with `coin_small`=1 and `coin_large`=0 that keeps credit at or below 30 raises `credit` by 5 at that rising edge.
- R3: A cycle with `coin_large`=1 that keeps credit at or below 30 raises `credit` by 10 at that rising edge.
- R4: Coins accumulate over successive cycles. For example, 5 followed by 10 gives 15, and three 10s from zero give 30.
- R5: When both coin inputs are 1 in the same cycle, only 10 is added and the small coin has no effect on `credit`.
- R6: A coin that would carry the credit above 30 leaves `credit` unchanged, and `refused` is 1 for the cycle after that edge only.
- R7: `credit` never exceeds 30.
- R8: `at_cap` is 1 exactly when `credit` equals 30. While it is 1, any coin is refused.
- R9: In a cycle with no coin input, `credit` holds its value and `refused` is 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; coin inputs are sampled here |
| rst | input | 1 | Asynchronous active-high reset |
| coin_small | input | 1 | One-cycle pulse for a five-cent coin |
| coin_large | input | 1 | One-cycle pulse for a ten-cent coin |
| credit | output | 5 | Current credit in cents, unsigned |
| at_cap | output | 1 | High while credit equals the ceiling |
| refused | output | 1 | One-cycle pulse after a coin is refused |

## Verification
The bench builds the block with its default parameters: a 5-bit credit, coin values of 5 and 10, and a ceiling of 30. With these values the ceiling is reached both by three large coins and by a mix of coin sizes. Both refusal paths are exercised: a large coin at 25 and any coin at 30. The simultaneous-coin case is tested below the ceiling and at the ceiling.

// File: rtl/coin_tally.sv
module coin_tally #(
  parameter int WIDTH       = 5,
  parameter int SMALL_CENTS = 5,
  parameter int LARGE_CENTS = 10,
  parameter int CAP_CENTS   = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             coin_small,
  input  logic             coin_large,
  output logic [WIDTH-1:0] credit,
  output logic             at_cap,
  output logic             refused
);
  localparam logic [WIDTH-1:0] SMALL_W = WIDTH'(SMALL_CENTS);
  localparam logic [WIDTH-1:0] LARGE_W = WIDTH'(LARGE_CENTS);
  localparam logic [WIDTH-1:0] CAP_W   = WIDTH'(CAP_CENTS);
  localparam logic [WIDTH:0]   CAP_X   = (WIDTH+1)'(CAP_CENTS);

  logic [WIDTH-1:0] coin_val;
  logic [WIDTH:0]   next_sum;
  logic             coin_seen;
  logic             over;

  assign coin_val  = coin_large ? LARGE_W : (coin_small ? SMALL_W : '0);
  assign coin_seen = coin_large | coin_small;
  assign next_sum  = {1'b0, credit} + {1'b0, coin_val};
  assign over      = next_sum > CAP_X;
  assign at_cap    = (credit == CAP_W);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      credit  <= '0;
      refused <= 1'b0;
    end else begin
      refused <= coin_seen & over;
      if (coin_seen && !over)
        credit <= next_sum[WIDTH-1:0];
    end
  end
endmodule

// File: rtl/coin_tally_chk.sv
module coin_tally_chk #(
  parameter int WIDTH       = 5,
  parameter int SMALL_CENTS = 5,
  parameter int LARGE_CENTS = 10,
  parameter int CAP_CENTS   = 30
) (
  input logic             clk,
  input logic             rst,
  input logic             coin_small,
  input logic             coin_large,
  input logic [WIDTH-1:0] credit,
  input logic             at_cap,
  input logic             refused
);
  // R7
  ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    int'(credit) <= CAP_CENTS);

  // R2
  small_add_chk: assert property (@(posedge clk) disable iff (rst)
    (coin_small && !coin_large && int'(credit) + SMALL_CENTS <= CAP_CENTS)
      |=> int'(credit) == int'($past(credit)) + SMALL_CENTS);

  // R5
  both_coin_chk: assert property (@(posedge clk) disable iff (rst)
    (coin_small && coin_large && int'(credit) + LARGE_CENTS <= CAP_CENTS)
      |=> int'(credit) == int'($past(credit)) + LARGE_CENTS);

  // R6
  reject_hold_chk: assert property (@(posedge clk) disable iff (rst)
    refused |-> credit == $past(credit));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!coin_small && !coin_large) |=> ($stable(credit) && !refused));

  // R8
  full_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (at_cap && (coin_small || coin_large)) |=> (refused && at_cap));
endmodule

bind coin_tally coin_tally_chk #(
  .WIDTH(WIDTH), .SMALL_CENTS(SMALL_CENTS),
  .LARGE_CENTS(LARGE_CENTS), .CAP_CENTS(CAP_CENTS)
) u_chk (
  .clk(clk), .rst(rst), .coin_small(coin_small), .coin_large(coin_large),
  .credit(credit), .at_cap(at_cap), .refused(refused)
);

// File: tb/coin_tally_test.sv
module coin_tally_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       coin_small = 1'b0;
  logic       coin_large = 1'b0;
  logic [4:0] credit;
  logic       at_cap;
  logic       refused;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  coin_tally uut (
    .clk(clk), .rst(rst), .coin_small(coin_small), .coin_large(coin_large),
    .credit(credit), .at_cap(at_cap), .refused(refused)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic insert(input logic s, input logic l);
    @(negedge clk);
    coin_small = s;
    coin_large = l;
    @(negedge clk);
    coin_small = 1'b0;
    coin_large = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    rst = 1'b1;
    #1;
    chk("R1 credit", int'(credit), 0);
    chk("R1 refused", int'(refused), 0);
    chk("R1 at_cap", int'(at_cap), 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_small_then_large;
    insert(1'b1, 1'b0);
    chk("R2 credit after small", int'(credit), 5);
    chk("R2 refused", int'(refused), 0);
    insert(1'b0, 1'b1);
    chk("R3 R4 credit after large", int'(credit), 15);
  endtask

  task automatic t_idle;
    for (int i = 0; i < 3; i++) @(negedge clk);
    chk("R9 credit held", int'(credit), 15);
    chk("R9 refused low", int'(refused), 0);
  endtask

  task automatic t_both;
    insert(1'b1, 1'b1);
    chk("R5 both coins", int'(credit), 25);
    chk("R8 at_cap low at 25", int'(at_cap), 0);
  endtask

  task automatic t_overflow_reject;
    insert(1'b0, 1'b1);
    chk("R6 credit unchanged", int'(credit), 25);
    chk("R6 refused pulse", int'(refused), 1);
    @(negedge clk);
    chk("R6 pulse one cycle", int'(refused), 0);
    insert(1'b1, 1'b0);
    chk("R2 fill to cap", int'(credit), 30);
    chk("R8 at_cap high", int'(at_cap), 1);
    chk("R6 accepted not refused", int'(refused), 0);
  endtask

  task automatic t_at_cap;
    insert(1'b1, 1'b0);
    chk("R7 small at cap", int'(credit), 30);
    chk("R8 refused at cap small", int'(refused), 1);
    insert(1'b0, 1'b1);
    chk("R7 large at cap", int'(credit), 30);
    chk("R8 refused at cap large", int'(refused), 1);
    insert(1'b1, 1'b1);
    chk("R7 both at cap", int'(credit), 30);
    chk("R5 both refused at cap", int'(refused), 1);
  endtask

  task automatic t_three_large;
    insert(1'b0, 1'b1);
    insert(1'b0, 1'b1);
    insert(1'b0, 1'b1);
    chk("R4 three large", int'(credit), 30);
    chk("R8 at_cap after three large", int'(at_cap), 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        t_small_then_large();
        t_idle();
        t_both();
        t_overflow_reject();
        t_at_cap();
        t_reset();
        t_three_large();
        t_reset();
      end
      begin
        repeat (5000) @(posedge clk);
        chk("watchdog expired", 1, 0);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule